// File: doc/BRIEF.md
# Mixed-Width Synchronous FIFO with Bit-Granular Threshold Flags

This block is a single-clock first-in first-out buffer whose write port and read port carry words of different widths, for example 2-bit writes drained as 4-bit reads, or 18-bit writes drained as 9-bit reads. Storage holds narrow units. A wide access touches several consecutive units in one cycle. Earlier data always sits in the lower bits of a wide read word.

Fill level is kept as the difference of two address counters that step in counted bits, not words. This lets one comparison serve both ports and both programmable thresholds. The almost-full and almost-empty levels are runtime inputs, also in bits. FULL and EMPTY describe whether a complete word can move on each port: EMPTY rises as soon as less than one read word is stored, and FULL rises as soon as less than one write word of room remains. Ports that are 9 or 18 bits wide carry one extra bit per byte, and that extra bit is not counted in the bit address space.

Top module: `mixw_fifo`

## Requirements
- R1: On the clock edge where the synchronous active-high reset `rst` is high, both address counters and `rd_data` clear. After that edge `empty` and `aempty` are 1, `full` is 0, and `afull` is 0 whenever `af_level` is nonzero.
- R2: Each accepted write adds the counted width of a write word to the write counter. Each accepted read adds the counted width of a read word to the read counter. Counters are ADDR_W+1 bits wide and wrap, so the stored level `wptr - rptr` ranges from 0 to 2**ADDR_W bits. A read and a write may be accepted in the same cycle.
- R3: `empty` is 1 exactly when the stored level is below the counted width of one read word. With 2-bit writes and 4-bit reads, one write still leaves `empty` at 1.
- R4: `full` is 1 exactly when 2**ADDR_W minus the level is below the counted width of one write word. With 18-bit writes and 9-bit reads, one read from a full buffer leaves `full` at 1. `full` and `empty` are never both 1.
- R5: A write presented while `full` is 1 is dropped. The counters and the stored data do not change.
- R6: A read presented while `empty` is 1 is dropped. The counters and `rd_data` do not change.
- R7: `afull` is 1 exactly when the level is greater than or equal to `af_level`.
- R8: `aempty` is 1 exactly when the level is less than or equal to `ae_level`.
- R9: `rd_data` is registered. It takes a new value on the clock edge that accepts a read, and it holds its value on all other edges. Within a read word, bit 0 is the oldest stored bit, so narrow words are returned in write order from the least significant end.
- R10: A port width that is a multiple of 9 counts 8 bits per 9 stored. With 18-bit writes and 9-bit reads, one write adds 16 to the level and one read removes 8. A 4096-bit space therefore becomes full after exactly 256 writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| rd_en | input | 1 | Read request |
| af_level | input | ADDR_W | Almost-full threshold in bits |
| ae_level | input | ADDR_W | Almost-empty threshold in bits |
| rd_data | output | RD_W | Registered read word |
| full | output | 1 | No room for a whole write word |
| empty | output | 1 | Less than a whole read word stored |
| afull | output | 1 | Level at or above `af_level` |
| aempty | output | 1 | Level at or below `ae_level` |

## Verification
The bound checker verifies the following on every cycle:
- the exact counter step of each accepted write;
- that counters and read data stay frozen for a request made against `full` or `empty`;
- that `rd_data` holds when no read is requested;
- that the level never exceeds the capacity;
- that `full` and `empty` are never both set.

Other behaviours only show up across a scenario:
- the order of the returned bits and their packing across widths;
- the exact fill point where each flag changes;
- the effect of runtime threshold values.

The bench checks these against a bit-queue reference model. A second instance with 18-bit writes and 9-bit reads shows the 8-of-9 counting rule and the partial-word FULL case.

// File: rtl/mixw_fifo_pkg.sv
package mixw_fifo_pkg;

    // Flag bundle produced by the level comparator.
    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
    } flag_set_t;

    // Bits of a port word that count toward the bit address space:
    // widths that are multiples of 9 carry one uncounted bit per byte.
    function automatic int counted_bits(input int w);
        if (w % 9 == 0) return (w / 9) * 8;
        return w;
    endfunction

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/mixw_fifo_ptrs.sv
module mixw_fifo_ptrs #(
    parameter int PW      = 13,
    parameter int WR_STEP = 2,
    parameter int RD_STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_go,
    input  logic          rd_go,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr
);
    localparam logic [PW-1:0] WINC = PW'(WR_STEP);
    localparam logic [PW-1:0] RINC = PW'(RD_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_go) wptr <= wptr + WINC;
            if (rd_go) rptr <= rptr + RINC;
        end
    end
endmodule

// File: rtl/mixw_fifo_flags.sv
module mixw_fifo_flags
    import mixw_fifo_pkg::*;
#(
    parameter int AW     = 12,
    parameter int WR_CNT = 2,
    parameter int RD_CNT = 4
) (
    input  logic [AW:0]   wptr,
    input  logic [AW:0]   rptr,
    input  logic [AW-1:0] af_lvl,
    input  logic [AW-1:0] ae_lvl,
    output flag_set_t     flags,
    output logic [AW:0]   level
);
    localparam logic [AW:0] CAP   = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] WNEED = (AW+1)'(WR_CNT);
    localparam logic [AW:0] RNEED = (AW+1)'(RD_CNT);

    logic [AW:0] room;

    always_comb begin
        level        = wptr - rptr;
        room         = CAP - level;
        flags.full   = room < WNEED;
        flags.empty  = level < RNEED;
        flags.afull  = level >= {1'b0, af_lvl};
        flags.aempty = level <= {1'b0, ae_lvl};
    end
endmodule

// File: rtl/mixw_fifo_store.sv
module mixw_fifo_store #(
    parameter int UNIT_W  = 2,
    parameter int WR_K    = 1,
    parameter int RD_K    = 2,
    parameter int SLOT_AW = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [SLOT_AW-1:0]     wslot,
    input  logic [WR_K*UNIT_W-1:0] wdata,
    input  logic                   re,
    input  logic [SLOT_AW-1:0]     rslot,
    output logic [RD_K*UNIT_W-1:0] rdata
);
    localparam int SLOTS = 1 << SLOT_AW;

    logic [UNIT_W-1:0]      mem [SLOTS];
    logic [RD_K*UNIT_W-1:0] rd_word;

    // Write: one unit per slot, lowest unit to the lowest slot.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < WR_K; i++) begin
                mem[wslot + SLOT_AW'(i)] <= wdata[i*UNIT_W +: UNIT_W];
            end
        end
    end

    // Read: gather consecutive slots, oldest unit in the low bits.
    for (genvar g = 0; g < RD_K; g++) begin : g_rd_gather
        assign rd_word[g*UNIT_W +: UNIT_W] = mem[rslot + SLOT_AW'(g)];
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= rd_word;
    end
endmodule

// File: rtl/mixw_fifo.sv
module mixw_fifo
    import mixw_fifo_pkg::*;
#(
    parameter int WR_W   = 2,
    parameter int RD_W   = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] af_level,
    input  logic [ADDR_W-1:0] ae_level,
    output logic [RD_W-1:0]   rd_data,
    output logic              full,
    output logic              empty,
    output logic              afull,
    output logic              aempty
);
    localparam int UNIT_W   = min_int(WR_W, RD_W);
    localparam int WR_K     = WR_W / UNIT_W;
    localparam int RD_K     = RD_W / UNIT_W;
    localparam int UNIT_CNT = counted_bits(UNIT_W);
    localparam int WR_CNT   = WR_K * UNIT_CNT;
    localparam int RD_CNT   = RD_K * UNIT_CNT;
    localparam int SH       = $clog2(UNIT_CNT);
    localparam int SLOT_AW  = ADDR_W - SH;

    logic [ADDR_W:0] wptr_q, rptr_q, level;
    flag_set_t       flg;
    logic            wr_go, rd_go;

    assign wr_go = wr_en && !flg.full;
    assign rd_go = rd_en && !flg.empty;

    mixw_fifo_ptrs #(
        .PW(ADDR_W + 1), .WR_STEP(WR_CNT), .RD_STEP(RD_CNT)
    ) u_ptrs (
        .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go),
        .wptr(wptr_q), .rptr(rptr_q)
    );

    mixw_fifo_flags #(
        .AW(ADDR_W), .WR_CNT(WR_CNT), .RD_CNT(RD_CNT)
    ) u_flags (
        .wptr(wptr_q), .rptr(rptr_q), .af_lvl(af_level), .ae_lvl(ae_level),
        .flags(flg), .level(level)
    );

    mixw_fifo_store #(
        .UNIT_W(UNIT_W), .WR_K(WR_K), .RD_K(RD_K), .SLOT_AW(SLOT_AW)
    ) u_store (
        .clk(clk), .rst(rst),
        .we(wr_go), .wslot(wptr_q[ADDR_W-1:SH]), .wdata(wr_data),
        .re(rd_go), .rslot(rptr_q[ADDR_W-1:SH]), .rdata(rd_data)
    );

    assign full   = flg.full;
    assign empty  = flg.empty;
    assign afull  = flg.afull;
    assign aempty = flg.aempty;
endmodule

// File: rtl/mixw_fifo_chk.sv
module mixw_fifo_chk #(
    parameter int RD_W    = 4,
    parameter int AW      = 12,
    parameter int WR_STEP = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            rd_en,
    input logic            full,
    input logic            empty,
    input logic [RD_W-1:0] rd_data,
    input logic [AW:0]     wptr,
    input logic [AW:0]     rptr
);
    localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};

    assert_no_full_and_empty_R4: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_wr_dropped_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en) |=> wptr == $past(wptr));

    assert_rd_dropped_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en) |=> (rptr == $past(rptr)) && (rd_data == $past(rd_data)));

    assert_wr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full) |=> wptr == $past(wptr) + (AW+1)'(WR_STEP));

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (wptr - rptr) <= CAP);

    assert_rd_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind mixw_fifo mixw_fifo_chk #(
    .RD_W(RD_W), .AW(ADDR_W), .WR_STEP(WR_CNT)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .full(full), .empty(empty), .rd_data(rd_data),
    .wptr(wptr_q), .rptr(rptr_q)
);

// File: tb/mixw_fifo_bench.sv
module mixw_fifo_bench;
    localparam int CAPB = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    // main instance: 2-bit writes, 4-bit reads
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  wr_data = '0;
    logic [11:0] af_level = 12'd1500, ae_level = 12'd200;
    logic [3:0]  rd_data;
    logic        full, empty, afull, aempty;

    mixw_fifo #(.WR_W(2), .RD_W(4), .ADDR_W(12)) u_mixw_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .af_level(af_level), .ae_level(ae_level), .rd_data(rd_data),
        .full(full), .empty(empty), .afull(afull), .aempty(aempty)
    );

    // second instance: 18-bit writes, 9-bit reads
    logic        b_wr_en = 1'b0, b_rd_en = 1'b0;
    logic [17:0] b_wr_data = '0;
    logic [8:0]  b_rd_data;
    logic        b_full, b_empty, b_afull, b_aempty;

    mixw_fifo #(.WR_W(18), .RD_W(9), .ADDR_W(12)) u_mixw_fifo_b (
        .clk(clk), .rst(rst), .wr_en(b_wr_en), .wr_data(b_wr_data), .rd_en(b_rd_en),
        .af_level(12'd4000), .ae_level(12'd0), .rd_data(b_rd_data),
        .full(b_full), .empty(b_empty), .afull(b_afull), .aempty(b_aempty)
    );

    // reference model: queue of stored bits, oldest first
    logic       mq[$];
    logic [3:0] exp_rd = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] wd, input logic re);
        int  lvl;
        bit  m_full, m_empty, acc_w, acc_r;
        @(negedge clk);
        wr_en = we; wr_data = wd; rd_en = re;
        #1;
        lvl     = mq.size();
        m_empty = lvl < 4;
        m_full  = (CAPB - lvl) < 2;
        chk("R9 rd_data", 32'(rd_data), 32'(exp_rd));
        chk("R3 empty", 32'(empty), 32'(m_empty));
        chk("R4 full", 32'(full), 32'(m_full));
        chk("R7 afull", 32'(afull), 32'(lvl >= int'(af_level)));
        chk("R8 aempty", 32'(aempty), 32'(lvl <= int'(ae_level)));
        acc_w = we && !m_full;   // R5: dropped when full
        acc_r = re && !m_empty;  // R6: dropped when empty
        @(posedge clk);
        if (acc_r) for (int i = 0; i < 4; i++) exp_rd[i] = mq.pop_front();
        if (acc_w) begin mq.push_back(wd[0]); mq.push_back(wd[1]); end
    endtask

    task automatic b_cyc(input logic we, input logic [17:0] wd, input logic re);
        @(negedge clk);
        b_wr_en = we; b_wr_data = wd; b_rd_en = re;
        @(posedge clk);
        #2;
        b_wr_en = 1'b0; b_rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [17:0] da;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 empty", 32'(empty), 1);
        chk("R1 aempty", 32'(aempty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 afull", 32'(afull), 0);
        chk("R1 rd_data", 32'(rd_data), 0);

        // R6: read on empty, R3: one 2-bit write keeps empty
        step(0, 2'd0, 1);
        step(1, 2'b01, 0);
        step(1, 2'b10, 0);   // R3: now 4 bits stored
        step(0, 2'd0, 1);    // R9: read gives {10,01}
        step(0, 2'd0, 0);
        chk("R9 packing", 32'(rd_data), 32'(4'b1001));

        // R2/R7/R4 fill to full, then writes are dropped (R5)
        for (int i = 0; i < 2050; i++) step(1, 2'(i * 3 + 1), 0);
        step(1, 2'b11, 0);
        // simultaneous read/write at full: only read proceeds
        step(1, 2'b00, 1);
        // drain through thresholds (R8)
        for (int i = 0; i < 1030; i++) step(0, 2'd0, 1);
        step(0, 2'd0, 1);    // R6 read on empty

        // mixed traffic with different thresholds
        af_level = 12'd64; ae_level = 12'd16;
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, 2'($urandom), ($urandom % 3) == 0);
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) == 0, 2'($urandom), ($urandom % 4) != 0);
        af_level = 12'd4095; ae_level = 12'd4095;
        for (int i = 0; i < 300; i++)
            step($urandom % 2 == 0, 2'($urandom), $urandom % 2 == 0);
        step(0, 2'd0, 0);

        // R10 second instance: 18-bit write, 9-bit reads
        #1;
        chk("R1 b empty", 32'(b_empty), 1);
        chk("R1 b full", 32'(b_full), 0);
        da = 18'h2A5C3;
        b_cyc(1, da, 0);
        chk("R10 b empty after one write", 32'(b_empty), 0);
        b_cyc(0, 18'd0, 1);
        chk("R9 b low half", 32'(b_rd_data), 32'(da[8:0]));
        b_cyc(0, 18'd0, 1);
        chk("R9 b high half", 32'(b_rd_data), 32'(da[17:9]));
        chk("R3 b empty", 32'(b_empty), 1);
        for (int i = 0; i < 255; i++) b_cyc(1, 18'(i * 1031 + 5), 0);
        chk("R10 b not full at 255", 32'(b_full), 0);
        b_cyc(1, 18'h3FFFF, 0);
        chk("R10 b full at 256", 32'(b_full), 1);
        b_cyc(0, 18'd0, 1);
        chk("R9 b first word", 32'(b_rd_data), 32'(9'd5));
        chk("R4 b full after one narrow read", 32'(b_full), 1);
        b_cyc(0, 18'd0, 1);
        chk("R4 b full released", 32'(b_full), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule